// File: doc/BRIEF.md
# Dual-Order Colour Palette

This block holds a palette of 32 colour words, 16 bits each, loaded by single-word writes on a register bus. Each accepted write is stored in two copies during the same clock cycle. One copy is indexed in plain order. The other is indexed with the five index bits rearranged. Logic further down the display pipe can then join its playfield bits in whatever order it naturally produces them and use the result directly as a lookup key, whether it later settles on one combined playfield or two separate ones.

Two combinational read ports look into the copies, one port for each. Writes to words outside the palette window, writes to odd addresses, and bus cycles without the write strobe are ignored. After reset both copies hold zero.

Top module: `pal_dual_store`

## Requirements
- R1: The palette holds 32 entries of 16 bits at even word addresses 0x180 to 0x1BE. A write to address A targets linear entry (A - 0x180) / 2.
- R2: Write data bits 15:8 land in the upper byte of the entry and bits 7:0 in its lower byte, so a linear read returns the written word unchanged.
- R3: The swizzled copy stores a write for linear index i = {i4,i3,i2,i1,i0} at swizzled index s, where s0 = i0, s1 = i2, s2 = i4, s3 = i1 and s4 = i3.
- R4: One accepted write updates the linear copy and the swizzled copy on the same clock edge.
- R5: A write to an address below 0x180 or above 0x1BE changes neither copy.
- R6: A write to an odd address changes neither copy.
- R7: After reset every entry of both copies reads zero.
- R8: The read ports are combinational on the index. A write shows on them after the clock edge that accepts it and not before that edge.
- R9: Bus cycles with the write strobe low change neither copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both copies |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Word address of the write |
| wr_data | input | 16 | Colour word to store |
| lin_rd_idx | input | 5 | Index into the linear copy |
| lin_rd_data | output | 16 | Entry of the linear copy at lin_rd_idx |
| swz_rd_idx | input | 5 | Index into the swizzled copy |
| swz_rd_data | output | 16 | Entry of the swizzled copy at swz_rd_idx |

## Verification
All 32 palette addresses are written with distinct words that differ in both bytes. Full sweeps of both read ports then show whether the linear mapping, the byte order and the bit rearrangement are correct, because a wrong permutation puts a word at an index whose expected value is different. A read just before the write edge and another just after it separate combinational reads from a stale or early update. Writes just below and just above the window, at odd addresses, and with the strobe low are each followed by a full sweep, which exposes a decoder that accepts them or aliases them onto a real entry.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int IDX_W  = 5;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } colour_t;

    // Rearranges a linear index into the swizzled copy's index.
    function automatic logic [IDX_W-1:0] swz_map(input logic [IDX_W-1:0] i);
        return {i[3], i[1], i[4], i[2], i[0]};
    endfunction
endpackage

// File: rtl/pal_addr_decode.sv
module pal_addr_decode #(
    parameter int ADDR_W  = 9,
    parameter int ENTRIES = 32,
    parameter int BASE    = 'h180,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = 2 * ENTRIES;

    logic [ADDR_W-1:0] offset;
    logic              in_window;

    always_comb begin
        offset    = wr_addr - ADDR_W'(BASE);
        in_window = (int'(wr_addr) >= BASE) && (int'(offset) < SPAN);
        hit       = wr_en && !wr_addr[0] && in_window;
        idx       = offset[IDX_W:1];
    end
endmodule

// File: rtl/pal_index_swizzle.sv
module pal_index_swizzle
    import pal_pkg::*;
(
    input  logic [IDX_W-1:0] lin_idx,
    output logic [IDX_W-1:0] swz_idx
);
    always_comb swz_idx = swz_map(lin_idx);
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [ENTRIES-1:0][DATA_W-1:0] mem;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mem[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb rdata = st_q.mem[ridx];
endmodule

// File: rtl/pal_dual_store.sv
module pal_dual_store
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int ENTRIES = 32,
    parameter int BASE    = 'h180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [4:0]        lin_rd_idx,
    output logic [15:0]       lin_rd_data,
    input  logic [4:0]        swz_rd_idx,
    output logic [15:0]       swz_rd_data
);
    logic             w_hit;
    logic [IDX_W-1:0] w_lin_idx;
    logic [IDX_W-1:0] w_swz_idx;
    colour_t          w_colour;

    always_comb begin
        w_colour.hi = wr_data[15:8];
        w_colour.lo = wr_data[7:0];
    end

    pal_addr_decode #(
        .ADDR_W (ADDR_W),
        .ENTRIES(ENTRIES),
        .BASE   (BASE)
    ) dec_i (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .hit    (w_hit),
        .idx    (w_lin_idx)
    );

    pal_index_swizzle swz_i (
        .lin_idx(w_lin_idx),
        .swz_idx(w_swz_idx)
    );

    pal_bank #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) lin_bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (w_hit),
        .widx (w_lin_idx),
        .wdata(w_colour),
        .ridx (lin_rd_idx),
        .rdata(lin_rd_data)
    );

    pal_bank #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) swz_bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (w_hit),
        .widx (w_swz_idx),
        .wdata(w_colour),
        .ridx (swz_rd_idx),
        .rdata(swz_rd_data)
    );
endmodule

// File: rtl/pal_dual_store_chk.sv
module pal_dual_store_chk
    import pal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [8:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic [4:0]  lin_rd_idx,
    input logic [15:0] lin_rd_data,
    input logic [4:0]  swz_rd_idx,
    input logic [15:0] swz_rd_data
);
    logic       ok_w;
    logic [4:0] exp_idx;

    always_comb begin
        ok_w    = wr_en && !wr_addr[0] && (wr_addr >= 9'h180) && (wr_addr <= 9'h1BE);
        exp_idx = 5'((wr_addr - 9'h180) >> 1);
    end

    // R4
    lin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_w |=> ((lin_rd_idx == $past(exp_idx)) -> (lin_rd_data == $past(wr_data))));

    // R3
    swz_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_w |=> ((swz_rd_idx == swz_map($past(exp_idx))) -> (swz_rd_data == $past(wr_data))));

    // R5
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_w |=> (($stable(lin_rd_idx) && $stable(swz_rd_idx)) ->
                   ($stable(lin_rd_data) && $stable(swz_rd_data))));

    // R4
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swz_rd_idx == swz_map(lin_rd_idx)) |-> (swz_rd_data == lin_rd_data));
endmodule

bind pal_dual_store pal_dual_store_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .lin_rd_idx (lin_rd_idx),
    .lin_rd_data(lin_rd_data),
    .swz_rd_idx (swz_rd_idx),
    .swz_rd_data(swz_rd_data)
);

// File: tb/pal_dual_store_tb_top.sv
`timescale 1ns/1ps
module pal_dual_store_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  lin_rd_idx = '0;
    logic [15:0] lin_rd_data;
    logic [4:0]  swz_rd_idx = '0;
    logic [15:0] swz_rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_lin [32];
    logic [15:0] m_swz [32];

    always #2.5 clk = ~clk;

    pal_dual_store dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lin_rd_idx(lin_rd_idx), .lin_rd_data(lin_rd_data),
        .swz_rd_idx(swz_rd_idx), .swz_rd_data(swz_rd_data)
    );

    function automatic logic [4:0] perm(input logic [4:0] i);
        logic [4:0] s;
        s[0] = i[0]; s[1] = i[2]; s[2] = i[4]; s[3] = i[1]; s[4] = i[3];
        return s;
    endfunction

    function automatic logic [15:0] pat(input int i);
        logic [7:0] h, l;
        h = 8'(i * 9 + 'h40);
        l = 8'('hC3 ^ (i * 3));
        return {h, l};
    endfunction

    task automatic cmp(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            lin_rd_idx = 5'(i);
            swz_rd_idx = 5'(i);
            #1;
            cmp({req, " linear"}, lin_rd_data, m_lin[i]);
            cmp({req, " swizzled"}, swz_rd_data, m_swz[i]);
        end
    endtask

    task automatic bus_write(input logic en, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_lin[i] = '0;
            m_swz[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: both copies clear after reset
        sweep("R7");

        // R1 R3 R4 R8: write each address, read just before and after its edge
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 9'('h180 + 2 * i);
            wr_data = pat(i);
            lin_rd_idx = 5'(i);
            swz_rd_idx = perm(5'(i));
            #1;
            cmp("R8 before edge linear", lin_rd_data, m_lin[i]);
            cmp("R8 before edge swizzled", swz_rd_data, m_swz[perm(5'(i))]);
            m_lin[i] = pat(i);
            m_swz[perm(5'(i))] = pat(i);
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            cmp("R4 linear after edge", lin_rd_data, m_lin[i]);
            cmp("R4 swizzled after edge", swz_rd_data, m_swz[perm(5'(i))]);
        end
        sweep("R1 R3 full load");

        // R2: byte placement
        bus_write(1'b1, 9'h18A, 16'hA55A);
        m_lin[5] = 16'hA55A;
        m_swz[perm(5'd5)] = 16'hA55A;
        @(negedge clk);
        lin_rd_idx = 5'd5;
        #1;
        cmp("R2 upper byte", {8'h00, lin_rd_data[15:8]}, 16'h00A5);
        cmp("R2 lower byte", {8'h00, lin_rd_data[7:0]}, 16'h005A);

        // R5: outside the window
        bus_write(1'b1, 9'h17E, 16'hDEAD);
        bus_write(1'b1, 9'h1C0, 16'hBEEF);
        bus_write(1'b1, 9'h000, 16'h1234);
        bus_write(1'b1, 9'h1FE, 16'h4321);
        bus_write(1'b1, 9'h080, 16'h5555);
        sweep("R5 out of window");

        // R6: odd addresses
        bus_write(1'b1, 9'h181, 16'hF00D);
        bus_write(1'b1, 9'h1BF, 16'hCAFE);
        bus_write(1'b1, 9'h19B, 16'h0BAD);
        sweep("R6 odd address");

        // R9: strobe low
        bus_write(1'b0, 9'h180, 16'h7777);
        bus_write(1'b0, 9'h1BE, 16'h8888);
        sweep("R9 strobe low");

        // R7: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) begin
            m_lin[i] = '0;
            m_swz[i] = '0;
        end
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R7 re-reset");

        finish_run();
    end
endmodule